// File: doc/BRIEF.md
# Debug Breakpoint Rights Controller

This unit owns a small set of hardware breakpoints: by default two that watch instruction fetches and two that watch data accesses. Before software may program them, it has to claim them. It sends a system-control message whose type field is 06h. In the operand word that field sits in bits 15:8, so the full request word is 0x600, and the operand's type field drives the `req_type` port. The first claim receives a response word that packs how many breakpoints of each kind were handed over. Every later claim receives zero until the owner gives the rights back or the unit is reset.

While the rights are held, the owner programs one control register and one address register per breakpoint. Each control field carries two enable bits and two mode bits. An armed breakpoint compares the word address of each fetch or data access against its own register. A match of both address and access kind raises a break pulse, together with a vector that names the breakpoint. Nothing is loaded at reset: every register starts at zero, so no break can occur until software has set the unit up.

Ownership is tracked by a two-state machine. `OWN_FREE` moves to `OWN_HELD` on a rights request (the grant transition). `OWN_HELD` stays in place when a further request arrives (the deny transition). `OWN_HELD` returns to `OWN_FREE` when `release_own` is high (the release transition).

Top module: `bkpt_rights_ctrl`

## Requirements
- R1: A request with `req_type` = 06h made while the rights are free produces, on the next cycle, `rsp_valid` = 1 and `rsp_data` = 0x00000022. Bits 7:4 carry the data-breakpoint count and bits 3:0 carry the instruction-breakpoint count. The requester then holds the rights.
- R2: A request with `req_type` = 06h made while the rights are held produces, on the next cycle, `rsp_valid` = 1 and `rsp_data` = 0, meaning nothing was granted.
- R3: Bits 31:8 of every response are zero.
- R4: A request with any other `req_type` produces no response and leaves ownership unchanged.
- R5: `release_own` high while the rights are held frees them, so the next request is granted again. `release_own` while the rights are free has no effect.
- R6: A write made while the rights are not held changes no register. Reads always return the current contents.
- R7: While the rights are held, a write takes effect and is visible on `rd_data` on the next cycle. Select 0 is the control register. Selects 1 and 2 are instruction slots 0 and 1. Selects 3 and 4 are data slots 0 and 1. The mode bits of the instruction slots always read as zero.
- R8: After reset every register reads zero, the rights are free, and `rsp_valid`, `brk_pulse` and `brk_hit` are zero.
- R9: For an armed instruction slot, a fetch whose word address equals bits 31:2 of that slot's address register sets `brk_pulse` and the slot's bit of `brk_hit` one cycle later. Bits 0 and 1 of `brk_hit` are instruction slots 0 and 1; bits 2 and 3 are data slots 0 and 1.
- R10: The control field of slot k occupies bits 4k+3:4k, with the enables in bits 3:2 and the mode in bits 1:0. A slot is armed only when both enable bits are 1.
- R11: A data slot in mode 01 fires on data writes only.
- R12: A data slot fires as follows by mode: mode 10 on data reads and writes but not on fetches; mode 11 on any access, fetches included; mode 00 on fetches only.
- R13: Each matching access produces a break pulse one cycle long. With no further matching access, `brk_pulse` and `brk_hit` return to zero on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A system-control message is presented |
| req_type | input | 8 | Message-type field (operand bits 15:8) |
| release_own | input | 1 | Give back the breakpoint rights |
| rsp_valid | output | 1 | Response word is valid |
| rsp_data | output | 32 | Packed count of breakpoints granted |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for writes |
| wr_data | input | 32 | Write data |
| rd_sel | input | 3 | Register select for reads |
| rd_data | output | 32 | Read data (combinational) |
| fetch_valid | input | 1 | Instruction fetch this cycle |
| fetch_waddr | input | 30 | Fetch word address (byte address bits 31:2) |
| data_valid | input | 1 | Data access this cycle |
| data_write | input | 1 | Data access is a write (0 = read) |
| data_waddr | input | 30 | Data word address (byte address bits 31:2) |
| brk_pulse | output | 1 | Break event |
| brk_hit | output | 4 | Breakpoints that matched |

## Verification
Responses and break outputs are each one register stage deep. Both are due on the cycle after the one in which the request or access is presented. A register write is visible on the combinational read port the cycle after the write strobe. The bench drives every stimulus on a falling edge and removes it on the next falling edge, with one rising edge in between. It samples at that second falling edge, and for reads it waits a short settling delay after changing the select. Every comparison therefore lands exactly on the cycle where the result is due, and the idle cycle after a hit confirms the pulse has ended.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

    // Ownership of the breakpoint resources
    typedef enum logic [0:0] {
        OWN_FREE = 1'b0,
        OWN_HELD = 1'b1
    } own_state_e;

    // Access kind a data slot reacts to
    typedef enum logic [1:0] {
        MD_FETCH = 2'b00,
        MD_WRITE = 2'b01,
        MD_DATA  = 2'b10,
        MD_ANY   = 2'b11
    } bp_mode_e;

    localparam logic [7:0] MSG_BP_RIGHTS = 8'h06;
    localparam int         FIELD_W       = 4;

endpackage

// File: rtl/bkpt_grant_fsm.sv
module bkpt_grant_fsm
    import bkpt_pkg::*;
#(
    parameter int N_IBP = 2,
    parameter int N_DBP = 2,
    parameter int DW    = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [7:0]    req_type,
    input  logic          release_own,
    output logic          owned,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data
);

    localparam logic [3:0]    I_CNT      = 4'(N_IBP);
    localparam logic [3:0]    D_CNT      = 4'(N_DBP);
    localparam logic [DW-1:0] GRANT_WORD = {{(DW-8){1'b0}}, D_CNT, I_CNT};

    own_state_e state_q;
    own_state_e state_d;
    logic       rights_req;

    assign rights_req = req_valid && (req_type == MSG_BP_RIGHTS);
    assign owned      = (state_q == OWN_HELD);

    // Next-state: grant, deny (stay), release
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OWN_FREE: if (rights_req)  state_d = OWN_HELD;
            OWN_HELD: if (release_own) state_d = OWN_FREE;
            default:  state_d = OWN_FREE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= OWN_FREE;
        else        state_q <= state_d;
    end

    // Registered response
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= rights_req;
            unique case (state_q)
                OWN_FREE: rsp_data <= rights_req ? GRANT_WORD : '0;
                OWN_HELD: rsp_data <= '0;
                default:  rsp_data <= '0;
            endcase
        end
    end

endmodule

// File: rtl/bkpt_regfile.sv
module bkpt_regfile
    import bkpt_pkg::*;
#(
    parameter int N_IBP = 2,
    parameter int NBP   = 4,
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int SW    = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       owned,
    input  logic                       wr_en,
    input  logic [SW-1:0]              wr_sel,
    input  logic [DW-1:0]              wr_data,
    input  logic [SW-1:0]              rd_sel,
    output logic [DW-1:0]              rd_data,
    output logic [FIELD_W*NBP-1:0]     ctrl_q,
    output logic [NBP-1:0][AW-3:0]     bp_waddr
);

    localparam int CW = FIELD_W * NBP;

    // Instruction slots keep only their enable pair
    function automatic logic [CW-1:0] ctrl_mask();
        logic [CW-1:0] m;
        m = '0;
        for (int k = 0; k < NBP; k++) begin
            m[FIELD_W*k +: FIELD_W] = (k < N_IBP) ? 4'hC : 4'hF;
        end
        return m;
    endfunction

    localparam logic [CW-1:0] CTRL_MASK = ctrl_mask();

    logic          wr_ok;
    logic [AW-1:0] areg [NBP];

    assign wr_ok = owned && wr_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       ctrl_q <= '0;
        else if (wr_ok && wr_sel == '0)   ctrl_q <= wr_data[CW-1:0] & CTRL_MASK;
    end

    for (genvar k = 0; k < NBP; k++) begin : g_addr
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                               areg[k] <= '0;
            else if (wr_ok && wr_sel == SW'(k + 1))   areg[k] <= wr_data[AW-1:0];
        end
        assign bp_waddr[k] = areg[k][AW-1:2];
    end

    always_comb begin
        rd_data = '0;
        if (rd_sel == '0) rd_data[CW-1:0] = ctrl_q;
        for (int k = 0; k < NBP; k++) begin
            if (rd_sel == SW'(k + 1)) rd_data[AW-1:0] = areg[k];
        end
    end

endmodule

// File: rtl/bkpt_match.sv
module bkpt_match
    import bkpt_pkg::*;
#(
    parameter int N_IBP = 2,
    parameter int NBP   = 4,
    parameter int AW    = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [FIELD_W*NBP-1:0]     ctrl,
    input  logic [NBP-1:0][AW-3:0]     bp_waddr,
    input  logic                       fetch_valid,
    input  logic [AW-1:2]              fetch_waddr,
    input  logic                       data_valid,
    input  logic                       data_write,
    input  logic [AW-1:2]              data_waddr,
    output logic                       brk_pulse,
    output logic [NBP-1:0]             brk_hit
);

    logic [NBP-1:0] hit_d;

    for (genvar k = 0; k < NBP; k++) begin : g_slot
        logic [FIELD_W-1:0] fld;
        logic               armed;
        logic               f_match;
        bp_mode_e           md;

        assign fld     = ctrl[FIELD_W*k +: FIELD_W];
        assign armed   = fld[3] & fld[2];
        assign md      = bp_mode_e'(fld[1:0]);
        assign f_match = fetch_valid && (fetch_waddr == bp_waddr[k]);

        if (k < N_IBP) begin : g_inst
            assign hit_d[k] = armed && (md == MD_FETCH) && f_match;
        end else begin : g_data
            logic d_match;
            logic take;
            assign d_match = data_valid && (data_waddr == bp_waddr[k]);
            always_comb begin
                unique case (md)
                    MD_FETCH: take = f_match;
                    MD_WRITE: take = d_match && data_write;
                    MD_DATA:  take = d_match;
                    MD_ANY:   take = f_match || d_match;
                    default:  take = 1'b0;
                endcase
            end
            assign hit_d[k] = armed && take;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            brk_hit   <= '0;
            brk_pulse <= 1'b0;
        end else begin
            brk_hit   <= hit_d;
            brk_pulse <= |hit_d;
        end
    end

endmodule

// File: rtl/bkpt_rights_ctrl.sv
module bkpt_rights_ctrl
    import bkpt_pkg::*;
#(
    parameter int N_IBP = 2,
    parameter int N_DBP = 2,
    parameter int AW    = 32,
    parameter int DW    = 32,
    localparam int NBP  = N_IBP + N_DBP,
    localparam int SW   = $clog2(NBP + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    input  logic [7:0]     req_type,
    input  logic           release_own,
    output logic           rsp_valid,
    output logic [DW-1:0]  rsp_data,
    input  logic           wr_en,
    input  logic [SW-1:0]  wr_sel,
    input  logic [DW-1:0]  wr_data,
    input  logic [SW-1:0]  rd_sel,
    output logic [DW-1:0]  rd_data,
    input  logic           fetch_valid,
    input  logic [AW-1:2]  fetch_waddr,
    input  logic           data_valid,
    input  logic           data_write,
    input  logic [AW-1:2]  data_waddr,
    output logic           brk_pulse,
    output logic [NBP-1:0] brk_hit
);

    logic                      owned;
    logic [FIELD_W*NBP-1:0]    ctrl_q;
    logic [NBP-1:0][AW-3:0]    bp_waddr;

    bkpt_grant_fsm #(
        .N_IBP (N_IBP),
        .N_DBP (N_DBP),
        .DW    (DW)
    ) u_grant (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_type    (req_type),
        .release_own (release_own),
        .owned       (owned),
        .rsp_valid   (rsp_valid),
        .rsp_data    (rsp_data)
    );

    bkpt_regfile #(
        .N_IBP (N_IBP),
        .NBP   (NBP),
        .AW    (AW),
        .DW    (DW),
        .SW    (SW)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .owned    (owned),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .rd_sel   (rd_sel),
        .rd_data  (rd_data),
        .ctrl_q   (ctrl_q),
        .bp_waddr (bp_waddr)
    );

    bkpt_match #(
        .N_IBP (N_IBP),
        .NBP   (NBP),
        .AW    (AW)
    ) u_match (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl        (ctrl_q),
        .bp_waddr    (bp_waddr),
        .fetch_valid (fetch_valid),
        .fetch_waddr (fetch_waddr),
        .data_valid  (data_valid),
        .data_write  (data_write),
        .data_waddr  (data_waddr),
        .brk_pulse   (brk_pulse),
        .brk_hit     (brk_hit)
    );

endmodule

// File: rtl/bkpt_rights_ctrl_chk.sv
module bkpt_rights_ctrl_chk #(
    parameter int N_IBP = 2,
    parameter int N_DBP = 2,
    parameter int DW    = 32,
    parameter int NBP   = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           req_valid,
    input logic [7:0]     req_type,
    input logic           release_own,
    input logic           owned,
    input logic           rsp_valid,
    input logic [DW-1:0]  rsp_data,
    input logic [4*NBP-1:0] ctrl_q,
    input logic           fetch_valid,
    input logic           data_valid,
    input logic           brk_pulse,
    input logic [NBP-1:0] brk_hit
);

    localparam logic [DW-1:0] GRANT = {{(DW-8){1'b0}}, 4'(N_DBP), 4'(N_IBP)};

    logic is_req;
    assign is_req = req_valid && (req_type == 8'h06);

    p_grant_r1: assert property (@(posedge clk) disable iff (!rst_n)
        is_req && !owned |=> rsp_valid && rsp_data == GRANT);

    p_deny_r2: assert property (@(posedge clk) disable iff (!rst_n)
        is_req && owned |=> rsp_valid && rsp_data == '0);

    p_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rsp_data[DW-1:8] == '0);

    p_no_rsp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !is_req |=> !rsp_valid);

    p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        owned && release_own |=> !owned);

    p_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !owned |=> $stable(ctrl_q));

    p_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        brk_pulse |-> $past(fetch_valid || data_valid));

    p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q == '0 |=> brk_hit == '0);

    p_single_r13: assert property (@(posedge clk) disable iff (!rst_n)
        brk_pulse && !fetch_valid && !data_valid |=> !brk_pulse);

endmodule

bind bkpt_rights_ctrl bkpt_rights_ctrl_chk #(
    .N_IBP (N_IBP),
    .N_DBP (N_DBP),
    .DW    (DW),
    .NBP   (NBP)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_type    (req_type),
    .release_own (release_own),
    .owned       (owned),
    .rsp_valid   (rsp_valid),
    .rsp_data    (rsp_data),
    .ctrl_q      (ctrl_q),
    .fetch_valid (fetch_valid),
    .data_valid  (data_valid),
    .brk_pulse   (brk_pulse),
    .brk_hit     (brk_hit)
);

// File: tb/bkpt_rights_ctrl_test.sv
`timescale 1ns/1ps
module bkpt_rights_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [7:0]  req_type = '0;
    logic        release_own = 1'b0;
    logic        rsp_valid;
    logic [31:0] rsp_data;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_sel = '0;
    logic [31:0] rd_data;
    logic        fetch_valid = 1'b0;
    logic [31:2] fetch_waddr = '0;
    logic        data_valid = 1'b0;
    logic        data_write = 1'b0;
    logic [31:2] data_waddr = '0;
    logic        brk_pulse;
    logic [3:0]  brk_hit;

    int n_run  = 0;
    int n_fail = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    bkpt_rights_ctrl uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_type(req_type),
        .release_own(release_own), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
        .rd_data(rd_data), .fetch_valid(fetch_valid), .fetch_waddr(fetch_waddr),
        .data_valid(data_valid), .data_write(data_write), .data_waddr(data_waddr),
        .brk_pulse(brk_pulse), .brk_hit(brk_hit)
    );

    // kind: 1 fetch, 2 data read, 3 data write; {kind, byte address, expected hit}
    localparam int NV = 10;
    localparam logic [37:0] VEC [NV] = '{
        {2'd1, 32'h0000_1000, 4'b0001},   // R9 exact word
        {2'd1, 32'h0000_1003, 4'b0001},   // R9 same word, other byte
        {2'd1, 32'h0000_1004, 4'b0000},   // R9 next word
        {2'd1, 32'h0000_2000, 4'b0000},   // R10 one enable only
        {2'd3, 32'h0000_3000, 4'b0100},   // R11 write hits
        {2'd2, 32'h0000_3000, 4'b0000},   // R11 read ignored
        {2'd2, 32'h0000_4002, 4'b1000},   // R12 mode 10 read
        {2'd3, 32'h0000_4000, 4'b1000},   // R12 mode 10 write
        {2'd1, 32'h0000_4000, 4'b0000},   // R12 mode 10 no fetch
        {2'd1, 32'h0000_3000, 4'b0000}    // R11 mode 01 no fetch
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send_req(input logic [31:0] op);
        @(negedge clk);
        req_valid = 1'b1;
        req_type  = op[15:8];
        @(negedge clk);
        req_valid = 1'b0;
        req_type  = '0;
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] sel, output logic [31:0] d);
        rd_sel = sel;
        #0.5;
        d = rd_data;
    endtask

    task automatic access(input logic [1:0] kind, input logic [31:0] a);
        @(negedge clk);
        fetch_valid = (kind == 2'd1);
        fetch_waddr = a[31:2];
        data_valid  = (kind >= 2'd2);
        data_write  = (kind == 2'd3);
        data_waddr  = a[31:2];
        @(negedge clk);
        fetch_valid = 1'b0; data_valid = 1'b0; data_write = 1'b0;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog (all requirements): actual %0d cycles expected < 20000", cycles);
            finish_run();
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R8 reset state
        chk("R8 rsp_valid", {31'b0, rsp_valid}, 32'h0);
        chk("R8 brk", {27'b0, brk_pulse, brk_hit}, 32'h0);
        for (int s = 0; s < 5; s++) begin
            rd(3'(s), v);
            chk("R8 reg", v, 32'h0);
        end

        // R6 writes without rights
        wr(3'd0, 32'h0000_FFFF);
        wr(3'd1, 32'h1234_5678);
        rd(3'd0, v); chk("R6 ctrl locked", v, 32'h0);
        rd(3'd1, v); chk("R6 addr locked", v, 32'h0);

        // R4 wrong message type
        send_req(32'h0000_0500);
        chk("R4 no rsp", {31'b0, rsp_valid}, 32'h0);
        wr(3'd0, 32'h0000_000C);
        rd(3'd0, v); chk("R4 still free", v, 32'h0);

        // R5 release while free is harmless, then R1 grant
        @(negedge clk); release_own = 1'b1;
        @(negedge clk); release_own = 1'b0;
        send_req(32'h0000_0600);
        chk("R1 rsp_valid", {31'b0, rsp_valid}, 32'h1);
        chk("R1 grant word", rsp_data, 32'h0000_0022);
        chk("R3 upper zero", {8'b0, rsp_data[31:8]}, 32'h0);

        // R2 second request denied
        send_req(32'h0000_0600);
        chk("R2 rsp_valid", {31'b0, rsp_valid}, 32'h1);
        chk("R2 deny word", rsp_data, 32'h0);

        // R7 writes with rights; instruction-slot mode bits masked
        wr(3'd0, 32'h0000_FFFF);
        rd(3'd0, v); chk("R7 ctrl mask", v, 32'h0000_FFCC);
        wr(3'd1, 32'h0000_1000);
        wr(3'd2, 32'h0000_2000);
        wr(3'd3, 32'h0000_3000);
        wr(3'd4, 32'h0000_4000);
        wr(3'd0, 32'h0000_ED4C);
        rd(3'd0, v); chk("R7 ctrl", v, 32'h0000_ED4C);
        rd(3'd1, v); chk("R7 ia0", v, 32'h0000_1000);
        rd(3'd4, v); chk("R7 da1", v, 32'h0000_4000);

        // Table walk: R9 R10 R11 R12
        for (int i = 0; i < NV; i++) begin
            access(VEC[i][37:36], VEC[i][35:4]);
            chk($sformatf("R9-table hit vec %0d", i), {28'b0, brk_hit}, {28'b0, VEC[i][3:0]});
            chk($sformatf("R9-table pulse vec %0d", i), {31'b0, brk_pulse}, {31'b0, |VEC[i][3:0]});
        end

        // R13 pulse ends after one cycle
        access(2'd1, 32'h0000_1000);
        chk("R13 pulse", {31'b0, brk_pulse}, 32'h1);
        @(negedge clk);
        chk("R13 pulse drop", {27'b0, brk_pulse, brk_hit}, 32'h0);

        // R9 fetch and write together fire two slots
        @(negedge clk);
        fetch_valid = 1'b1; fetch_waddr = 30'h400;
        data_valid = 1'b1; data_write = 1'b1; data_waddr = 30'hC00;
        @(negedge clk);
        fetch_valid = 1'b0; data_valid = 1'b0; data_write = 1'b0;
        chk("R9 dual hit", {28'b0, brk_hit}, 32'h5);

        // R12 mode 11 on data slot 1
        wr(3'd0, 32'h0000_FD4C);
        access(2'd1, 32'h0000_4000);
        chk("R12 mode11 fetch", {28'b0, brk_hit}, 32'h8);
        access(2'd2, 32'h0000_4000);
        chk("R12 mode11 read", {28'b0, brk_hit}, 32'h8);

        // R12 mode 00 on data slot 1
        wr(3'd0, 32'h0000_CD4C);
        access(2'd2, 32'h0000_4000);
        chk("R12 mode00 read", {28'b0, brk_hit}, 32'h0);
        access(2'd1, 32'h0000_4000);
        chk("R12 mode00 fetch", {28'b0, brk_hit}, 32'h8);

        // R5 release then writes ignored, new grant succeeds
        @(negedge clk); release_own = 1'b1;
        @(negedge clk); release_own = 1'b0;
        wr(3'd0, 32'h0);
        rd(3'd0, v); chk("R5 released R6 locked", v, 32'h0000_CD4C);
        send_req(32'h0000_0600);
        chk("R5 regrant", rsp_data, 32'h0000_0022);

        // R8 reset clears everything
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        for (int s = 0; s < 5; s++) begin
            rd(3'(s), v);
            chk("R8 reg after reset", v, 32'h0);
        end
        access(2'd1, 32'h0000_1000);
        chk("R8 no break", {27'b0, brk_pulse, brk_hit}, 32'h0);
        send_req(32'h0000_0600);
        chk("R8 rights free", rsp_data, 32'h0000_0022);

        finish_run();
    end

endmodule